// File: doc/BRIEF.md
# Data Abort Write-Suppression Controller

This block sits beside a register file and decides which register writes a load/store instruction may make once one of its memory accesses has been aborted. A new instruction is announced with a one-cycle start strobe that carries its class (single transfer, swap or block transfer), its direction, its write-back flag, its base and destination registers, its register list, the updated base value and an early/late abort setting. The memory side then reports each beat with a strobe, an abort flag, the beat's address, a fault status code and, for loads, the loaded data.

The controller drives two register-file write ports. One carries loaded data. The other carries the base write-back. How the two ports are gated depends on the instruction class and on whether an abort has already been seen. On the first aborting beat of an instruction it records the faulting address and status. In the cycle after the instruction's last beat it raises a one-cycle request to enter the data abort handler.

Top module: `dabt_ctl`

## Requirements
- R1: After reset all write enables, the abort request and the fault address and status outputs are zero, and beat strobes (with or without abort) that arrive while no instruction is in progress have no effect on any output.
- R2: A single load (class code 0, load=1) without an abort writes the loaded data to its destination in the cycle after the beat. With write-back set, the base is written with the updated value in that same cycle, unless the destination is the base register, in which case only the loaded value is written.
- R3: A single transfer that aborts with the early setting (early=1) makes no register write of any kind, including the base write-back.
- R4: A single transfer that aborts with the late setting (early=0) drops the data write but still writes back the base when the write-back flag is set.
- R5: A swap (class code 1) takes two beats and writes the data captured on its first beat to the destination in the cycle after the second beat, only if neither beat aborted. A swap never writes the base.
- R6: A block load (class code 2) moves one register per beat in ascending register number order, taken from the 16-bit list. Each write appears in the cycle after its beat, and idle cycles between beats are allowed.
- R7: In a block transfer an abort does not end the instruction. All beats of the list still run, but no data write is made on the aborting beat or on any later beat, so register 15, which is always last, keeps its value.
- R8: A block transfer with write-back set writes the updated base in the cycle after its last beat whenever an abort occurred. Without an abort, it does so only if the base was not loaded from the list, so a base that was loaded before the abort ends up holding the write-back value.
- R9: The fault address and status outputs take the beat's address and status on the first aborting beat of an instruction only. Later aborting beats of the same instruction leave them unchanged.
- R10: The abort request is a one-cycle pulse in the cycle after the final beat of an instruction in which any beat aborted, and it stays low for instructions without an abort.
- R11: A store (load=0), single or block, makes no data writes, and its base write-back follows the same rules as a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Instruction start strobe, taken only when idle |
| cls_i | input | 2 | Class: 0 single, 1 swap, 2 block |
| load_i | input | 1 | 1 for load, 0 for store |
| wback_i | input | 1 | Base write-back requested |
| early_i | input | 1 | 1 early abort setting, 0 late |
| base_i | input | RW | Base register number |
| rd_i | input | RW | Destination register of single/swap |
| list_i | input | NREG | Block transfer register list |
| nbase_i | input | DW | Updated base value |
| beat_i | input | 1 | Memory beat completes this cycle |
| abort_i | input | 1 | This beat was aborted |
| addr_i | input | AW | Address of this beat |
| status_i | input | SW | Fault status code of this beat |
| data_i | input | DW | Data read by this beat |
| ld_we_o | output | 1 | Data write enable |
| ld_wa_o | output | RW | Data write register |
| ld_wd_o | output | DW | Data write value |
| wb_we_o | output | 1 | Base write-back enable |
| wb_wa_o | output | RW | Base write-back register |
| wb_wd_o | output | DW | Base write-back value |
| far_o | output | AW | Captured fault address |
| fsr_o | output | SW | Captured fault status |
| dabt_req_o | output | 1 | Data abort entry request pulse |

## Verification
The bench uses the default parameters: 16 registers, 32-bit data and address, and a 4-bit status. With these values a full 16-entry list runs as a 16-beat block transfer with register 15 on the final beat, so a late abort on exactly that beat can be checked. The 4-bit status is enough for every beat of such a list to carry a distinct code, which shows which abort was captured. The bench also places the base register both inside and outside the list, and it sends several aborts within one instruction.

// File: rtl/dabt_pkg.sv
package dabt_pkg;

  typedef enum logic [1:0] {
    XF_SINGLE = 2'd0,
    XF_SWAP   = 2'd1,
    XF_BLOCK  = 2'd2
  } xfer_cls_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctl_st_e;

  typedef struct packed {
    xfer_cls_e cls;
    logic      load;
    logic      wback;
    logic      early;
  } xfer_attr_t;

endpackage

// File: rtl/dabt_rst_sync.sv
module dabt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/dabt_seq.sv
// Beat sequencer: walks the register list lowest number first and
// flags the final beat of each instruction class.
module dabt_seq import dabt_pkg::*; #(
  parameter int NREG = 16,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [NREG-1:0] list_i,
  input  xfer_cls_e       cls,
  input  logic            adv,
  output logic [RW-1:0]   cur_reg,
  output logic            last_beat
);

  logic [NREG-1:0] rem_q, rem_nxt, rem_drop;
  logic            second_q, second_nxt;
  logic            seq_en;

  assign rem_drop = rem_q & (rem_q - NREG'(1));
  assign seq_en   = load_en | adv;

  // lowest set bit of the remaining list
  always_comb begin
    cur_reg = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (rem_q[i]) cur_reg = RW'(i);
    end
  end

  always_comb begin
    rem_nxt    = rem_q;
    second_nxt = second_q;
    if (load_en) begin
      rem_nxt    = list_i;
      second_nxt = 1'b0;
    end else if (adv) begin
      second_nxt = 1'b1;
      if (cls == XF_BLOCK) rem_nxt = rem_drop;
    end
  end

  always_comb begin
    case (cls)
      XF_SINGLE: last_beat = 1'b1;
      XF_SWAP:   last_beat = second_q;
      XF_BLOCK:  last_beat = (rem_drop == '0);
      default:   last_beat = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      second_q <= 1'b0;
    end else if (seq_en) begin
      rem_q    <= rem_nxt;
      second_q <= second_nxt;
    end
  end

endmodule

// File: rtl/dabt_policy.sv
// Per-class write gating, purely combinational.
module dabt_policy import dabt_pkg::*; (
  input  xfer_cls_e cls,
  input  logic      load,
  input  logic      wback,
  input  logic      early,
  input  logic      base_hit,
  input  logic      aborted_q,
  input  logic      abort_i,
  input  logic      adv,
  input  logic      last_beat,
  output logic      ld_go,
  output logic      wb_go,
  output logic      req_go,
  output logic      cap_go
);

  logic abt_now;
  logic ld_ok, wb_ok;

  assign abt_now = aborted_q | abort_i;

  always_comb begin
    ld_ok = 1'b0;
    wb_ok = 1'b0;
    case (cls)
      XF_SINGLE: begin
        ld_ok = load & ~abt_now;
        wb_ok = abt_now ? ~early : ~base_hit;
      end
      XF_SWAP: begin
        ld_ok = last_beat & ~abt_now;
        wb_ok = 1'b0;
      end
      XF_BLOCK: begin
        ld_ok = load & ~abt_now;
        wb_ok = abt_now | ~base_hit;
      end
      default: begin
        ld_ok = 1'b0;
        wb_ok = 1'b0;
      end
    endcase
  end

  assign ld_go  = adv & ld_ok;
  assign wb_go  = adv & last_beat & wback & wb_ok;
  assign req_go = adv & last_beat & abt_now;
  assign cap_go = adv & abort_i & ~aborted_q;

endmodule

// File: rtl/dabt_fault.sv
// Fault address / status capture.
module dabt_fault #(
  parameter int AW = 32,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_go,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] status_i,
  output logic [AW-1:0] far_o,
  output logic [SW-1:0] fsr_o
);

  logic [AW-1:0] far_q, far_nxt;
  logic [SW-1:0] fsr_q, fsr_nxt;

  always_comb begin
    far_nxt = addr_i;
    fsr_nxt = status_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      far_q <= '0;
      fsr_q <= '0;
    end else if (cap_go) begin
      far_q <= far_nxt;
      fsr_q <= fsr_nxt;
    end
  end

  assign far_o = far_q;
  assign fsr_o = fsr_q;

endmodule

// File: rtl/dabt_ctl.sv
module dabt_ctl import dabt_pkg::*; #(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int SW   = 4,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [1:0]      cls_i,
  input  logic            load_i,
  input  logic            wback_i,
  input  logic            early_i,
  input  logic [RW-1:0]   base_i,
  input  logic [RW-1:0]   rd_i,
  input  logic [NREG-1:0] list_i,
  input  logic [DW-1:0]   nbase_i,
  input  logic            beat_i,
  input  logic            abort_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [SW-1:0]   status_i,
  input  logic [DW-1:0]   data_i,
  output logic            ld_we_o,
  output logic [RW-1:0]   ld_wa_o,
  output logic [DW-1:0]   ld_wd_o,
  output logic            wb_we_o,
  output logic [RW-1:0]   wb_wa_o,
  output logic [DW-1:0]   wb_wd_o,
  output logic [AW-1:0]   far_o,
  output logic [SW-1:0]   fsr_o,
  output logic            dabt_req_o
);

  logic rst_sn;

  dabt_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  ctl_st_e    st_q, st_nxt;
  xfer_attr_t attr_q, attr_nxt;
  logic [RW-1:0] base_q, rd_q;
  logic [DW-1:0] nbase_q, swp_q;
  logic          hit_q, hit_nxt;
  logic          aborted_q, aborted_nxt;

  logic running, start_go, adv;
  logic [RW-1:0] cur_reg;
  logic last_beat;
  logic ld_go, wb_go, req_go, cap_go;
  logic swp_en, ab_en;

  logic          ld_we_q, wb_we_q, req_q;
  logic [RW-1:0] ld_wa_q, ld_wa_nxt, wb_wa_q;
  logic [DW-1:0] ld_wd_q, ld_wd_nxt, wb_wd_q;

  assign running  = (st_q == ST_RUN);
  assign start_go = ~running & start_i;
  assign adv      = running & beat_i;

  dabt_seq #(.NREG(NREG)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sn),
    .load_en   (start_go),
    .list_i    (list_i),
    .cls       (attr_q.cls),
    .adv       (adv),
    .cur_reg   (cur_reg),
    .last_beat (last_beat)
  );

  dabt_policy u_pol (
    .cls       (attr_q.cls),
    .load      (attr_q.load),
    .wback     (attr_q.wback),
    .early     (attr_q.early),
    .base_hit  (hit_q),
    .aborted_q (aborted_q),
    .abort_i   (abort_i),
    .adv       (adv),
    .last_beat (last_beat),
    .ld_go     (ld_go),
    .wb_go     (wb_go),
    .req_go    (req_go),
    .cap_go    (cap_go)
  );

  dabt_fault #(.AW(AW), .SW(SW)) u_fault (
    .clk      (clk),
    .rst_n    (rst_sn),
    .cap_go   (cap_go),
    .addr_i   (addr_i),
    .status_i (status_i),
    .far_o    (far_o),
    .fsr_o    (fsr_o)
  );

  // next-state logic
  always_comb begin
    st_nxt = st_q;
    if (start_go) begin
      st_nxt = ST_RUN;
    end else if (adv && last_beat) begin
      st_nxt = ST_IDLE;
    end
  end

  always_comb begin
    attr_nxt.cls   = xfer_cls_e'(cls_i);
    attr_nxt.load  = load_i;
    attr_nxt.wback = wback_i;
    attr_nxt.early = early_i;
    if (cls_i == XF_BLOCK) begin
      hit_nxt = load_i & list_i[base_i];
    end else begin
      hit_nxt = load_i & (rd_i == base_i);
    end
  end

  assign ab_en = start_go | (adv & abort_i);
  always_comb begin
    aborted_nxt = aborted_q;
    if (start_go) begin
      aborted_nxt = 1'b0;
    end else if (adv && abort_i) begin
      aborted_nxt = 1'b1;
    end
  end

  assign swp_en = adv & (attr_q.cls == XF_SWAP) & ~last_beat;

  always_comb begin
    ld_wa_nxt = (attr_q.cls == XF_BLOCK) ? cur_reg : rd_q;
    ld_wd_nxt = (attr_q.cls == XF_SWAP) ? swp_q : data_i;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      attr_q  <= '0;
      base_q  <= '0;
      rd_q    <= '0;
      nbase_q <= '0;
      hit_q   <= 1'b0;
    end else if (start_go) begin
      attr_q  <= attr_nxt;
      base_q  <= base_i;
      rd_q    <= rd_i;
      nbase_q <= nbase_i;
      hit_q   <= hit_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      aborted_q <= 1'b0;
    end else if (ab_en) begin
      aborted_q <= aborted_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      swp_q <= '0;
    end else if (swp_en) begin
      swp_q <= data_i;
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ld_we_q <= 1'b0;
      wb_we_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      ld_we_q <= ld_go;
      wb_we_q <= wb_go;
      req_q   <= req_go;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ld_wa_q <= '0;
      ld_wd_q <= '0;
    end else if (ld_go) begin
      ld_wa_q <= ld_wa_nxt;
      ld_wd_q <= ld_wd_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      wb_wa_q <= '0;
      wb_wd_q <= '0;
    end else if (wb_go) begin
      wb_wa_q <= base_q;
      wb_wd_q <= nbase_q;
    end
  end

  assign ld_we_o    = ld_we_q;
  assign ld_wa_o    = ld_wa_q;
  assign ld_wd_o    = ld_wd_q;
  assign wb_we_o    = wb_we_q;
  assign wb_wa_o    = wb_wa_q;
  assign wb_wd_o    = wb_wd_q;
  assign dabt_req_o = req_q;

endmodule

// File: rtl/dabt_ctl_chk.sv
module dabt_ctl_chk #(
  parameter int AW = 32,
  parameter int SW = 4,
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          running,
  input logic [1:0]    cls,
  input logic          early,
  input logic          beat_i,
  input logic          abort_i,
  input logic          aborted_q,
  input logic          ld_we_o,
  input logic [RW-1:0] ld_wa_o,
  input logic          wb_we_o,
  input logic [RW-1:0] wb_wa_o,
  input logic          dabt_req_o,
  input logic [AW-1:0] far_o,
  input logic [SW-1:0] fsr_o
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !(ld_we_o || wb_we_o || dabt_req_o))
    else $error("idle cycle produced a write or request");

  p_early_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && beat_i && cls == 2'd0 && early && abort_i) |=> !(ld_we_o || wb_we_o))
    else $error("early-aborted single transfer wrote a register");

  p_swap_no_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && beat_i && cls == 2'd1) |=> !wb_we_o)
    else $error("swap wrote the base");

  p_block_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && beat_i && cls == 2'd2 && aborted_q) |=> !ld_we_o)
    else $error("block transfer wrote data after an abort");

  p_port_disjoint_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_we_o && wb_we_o && ld_wa_o == wb_wa_o))
    else $error("both write ports target one register");

  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!running || aborted_q) |=> ($stable(far_o) && $stable(fsr_o)))
    else $error("fault registers changed without a first abort");

  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dabt_req_o |=> !dabt_req_o)
    else $error("abort request longer than one cycle");

  p_req_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dabt_req_o |-> aborted_q)
    else $error("abort request without an abort");

endmodule

bind dabt_ctl dabt_ctl_chk #(.AW(AW), .SW(SW), .RW(RW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sn),
  .running    (running),
  .cls        (attr_q.cls),
  .early      (attr_q.early),
  .beat_i     (beat_i),
  .abort_i    (abort_i),
  .aborted_q  (aborted_q),
  .ld_we_o    (ld_we_o),
  .ld_wa_o    (ld_wa_o),
  .wb_we_o    (wb_we_o),
  .wb_wa_o    (wb_wa_o),
  .dabt_req_o (dabt_req_o),
  .far_o      (far_o),
  .fsr_o      (fsr_o)
);

// File: tb/dabt_ctl_test.sv
`timescale 1ns/1ps
module dabt_ctl_test;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  cls_i;
  logic        load_i, wback_i, early_i;
  logic [3:0]  base_i, rd_i;
  logic [15:0] list_i;
  logic [31:0] nbase_i;
  logic        beat_i, abort_i;
  logic [31:0] addr_i;
  logic [3:0]  status_i;
  logic [31:0] data_i;
  logic        ld_we_o, wb_we_o, dabt_req_o;
  logic [3:0]  ld_wa_o, wb_wa_o;
  logic [31:0] ld_wd_o, wb_wd_o, far_o;
  logic [3:0]  fsr_o;

  dabt_ctl uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cls_i(cls_i),
    .load_i(load_i), .wback_i(wback_i), .early_i(early_i),
    .base_i(base_i), .rd_i(rd_i), .list_i(list_i), .nbase_i(nbase_i),
    .beat_i(beat_i), .abort_i(abort_i), .addr_i(addr_i),
    .status_i(status_i), .data_i(data_i),
    .ld_we_o(ld_we_o), .ld_wa_o(ld_wa_o), .ld_wd_o(ld_wd_o),
    .wb_we_o(wb_we_o), .wb_wa_o(wb_wa_o), .wb_wd_o(wb_wd_o),
    .far_o(far_o), .fsr_o(fsr_o), .dabt_req_o(dabt_req_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    int          kind;   // 0 data write, 1 base write-back, 2 abort request
    int          addr;
    logic [31:0] data;
    int          stamp;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          errors = 0;
  int          ncyc   = 0;
  int          wd     = 0;
  int          ntag   = 1;
  bit          done   = 0;
  bit          mon_on = 0;
  string       cur_tag = "R1";
  logic [31:0] far_exp = '0;
  logic [3:0]  fsr_exp = '0;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic push(input int kind, input int addr, input logic [31:0] data,
                      input int stamp);
    exp_t e;
    e.kind = kind; e.addr = addr; e.data = data; e.stamp = stamp;
    q.push_back(e);
  endtask

  task automatic chk_event(input int kind, input int addr, input logic [31:0] data);
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL %s unexpected event kind %0d reg %0d data %h at %0d (expected none)",
               cur_tag, kind, addr, data, ncyc);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.addr != addr || e.data != data || e.stamp != ncyc) begin
        errors++;
        $display("FAIL %s event actual kind %0d reg %0d data %h cyc %0d expected kind %0d reg %0d data %h cyc %0d",
                 cur_tag, kind, addr, data, ncyc, e.kind, e.addr, e.data, e.stamp);
      end
    end
  endtask

  // monitor: compares design events with the scoreboard queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (ld_we_o)    chk_event(0, int'(ld_wa_o), ld_wd_o);
      if (wb_we_o)    chk_event(1, int'(wb_wa_o), wb_wd_o);
      if (dabt_req_o) chk_event(2, 0, 32'h0);
      while (q.size() > 0 && q[0].stamp <= ncyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        errors++;
        $display("FAIL %s missing event actual none expected kind %0d reg %0d data %h cyc %0d",
                 cur_tag, e.kind, e.addr, e.data, e.stamp);
      end
    end
    ncyc++;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d cycles expected fewer than 20000", wd);
      finish_run();
    end
  end

  // driver: runs one instruction and pushes the expected events
  task automatic run(input string tag, input int cls, input bit load, input bit wback,
                     input bit early, input int base, input int rd,
                     input logic [15:0] list, input logic [15:0] amask, input bit gap);
    int          nbeats;
    int          r;
    bit          ab;
    bit          hit;
    bit          wb_ok;
    int          st;
    logic [31:0] sdat;
    logic [31:0] nb;
    cur_tag = tag;
    nb = 32'h0B00_0000 + 32'(ntag);
    ab = 0; r = -1; st = 0; sdat = '0;
    nbeats = (cls == 0) ? 1 : (cls == 1) ? 2 : $countones(list);
    @(posedge clk); #1;
    start_i = 1; cls_i = 2'(cls); load_i = load; wback_i = wback; early_i = early;
    base_i = 4'(base); rd_i = 4'(rd); list_i = list; nbase_i = nb;
    for (int b = 0; b < nbeats; b++) begin
      @(posedge clk); #1;
      start_i = 0;
      if (gap && b > 0) begin
        beat_i = 0; abort_i = 0;
        @(posedge clk); #1;
      end
      if (cls == 2) begin
        for (int j = r + 1; j < 16; j++) begin
          if (list[j]) begin r = j; break; end
        end
      end
      beat_i   = 1;
      abort_i  = amask[b];
      addr_i   = 32'h0000_4000 + 32'(ntag * 64) + 32'(b * 4);
      status_i = 4'(b + ntag + 1);
      data_i   = 32'hA500_0000 | (32'(ntag) << 8) | 32'(b);
      st = ncyc + 1;
      if (cls == 2 && load && !(ab || amask[b])) push(0, r, data_i, st);
      if (cls == 0 && load && !amask[b])          push(0, rd, data_i, st);
      if (cls == 1 && b == 0) sdat = data_i;
      if (amask[b] && !ab) begin
        far_exp = addr_i;
        fsr_exp = status_i;
      end
      if (amask[b]) ab = 1;
    end
    if (cls == 1 && !ab) push(0, rd, sdat, st);
    hit = load && ((cls == 2) ? list[base] : (rd == base));
    if (cls == 0)      wb_ok = ab ? !early : !hit;
    else if (cls == 2) wb_ok = ab || !hit;
    else               wb_ok = 0;
    if (wback && wb_ok) push(1, base, nb, st);
    if (ab) push(2, 0, 32'h0, st);
    @(posedge clk); #1;
    beat_i = 0; abort_i = 0;
    repeat (3) @(posedge clk);
    #1;
    check(q.size() == 0, tag, "pending events", 64'(q.size()), 64'h0);
    check(far_o == far_exp, "R9", "fault address", 64'(far_o), 64'(far_exp));
    check(fsr_o == fsr_exp, "R9", "fault status", 64'(fsr_o), 64'(fsr_exp));
    ntag++;
  endtask

  initial begin
    rst_n = 0; start_i = 0; cls_i = 0; load_i = 0; wback_i = 0; early_i = 0;
    base_i = 0; rd_i = 0; list_i = 0; nbase_i = 0; beat_i = 0; abort_i = 0;
    addr_i = 0; status_i = 0; data_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    check(!ld_we_o && !wb_we_o && !dabt_req_o, "R1", "write/request after reset",
          {61'h0, ld_we_o, wb_we_o, dabt_req_o}, 64'h0);
    check(far_o == 0 && fsr_o == 0, "R1", "fault registers after reset",
          {28'h0, fsr_o, far_o}, 64'h0);
    mon_on = 1;

    // R1: aborting beat while idle is ignored
    cur_tag = "R1";
    beat_i = 1; abort_i = 1; addr_i = 32'hDEAD_0000; status_i = 4'hF; data_i = 32'h1234;
    @(posedge clk); #1;
    beat_i = 0; abort_i = 0;
    repeat (3) @(posedge clk);
    #1;
    check(far_o == 0 && fsr_o == 0, "R1", "fault registers after idle beat",
          {28'h0, fsr_o, far_o}, 64'h0);

    // R2: single load, write-back, no abort
    run("R2", 0, 1, 1, 0, 5, 3, 16'h0, 16'h0, 0);
    // R2: single load into the base register
    run("R2", 0, 1, 1, 0, 6, 6, 16'h0, 16'h0, 0);
    // R3 / R10: single load early abort
    run("R3", 0, 1, 1, 1, 2, 9, 16'h0, 16'h1, 0);
    // R4: single load late abort keeps write-back
    run("R4", 0, 1, 1, 0, 4, 4, 16'h0, 16'h1, 0);
    // R11: single store, write-back
    run("R11", 0, 0, 1, 1, 7, 1, 16'h0, 16'h0, 0);
    // R5: swap without abort
    run("R5", 1, 1, 1, 0, 3, 8, 16'h0, 16'h0, 0);
    // R5: swap aborted on its second beat
    run("R5", 1, 1, 0, 1, 3, 8, 16'h0, 16'h2, 1);
    // R6: block load, gaps between beats, base outside the list
    run("R6", 2, 1, 1, 0, 2, 0, 16'h8093, 16'h0, 1);
    // R8: block load with base in the list, no abort
    run("R8", 2, 1, 1, 0, 4, 0, 16'h0070, 16'h0, 0);
    // R7 / R8 / R9 / R10: base loaded before abort, two aborting beats
    run("R7", 2, 1, 1, 0, 5, 0, 16'h80F0, 16'h000C, 0);
    // R11: block store aborted on first beat
    run("R11", 2, 0, 1, 0, 13, 0, 16'hFFFF, 16'h0001, 0);
    // R7: full list, abort on the R15 beat only
    run("R7", 2, 1, 0, 0, 0, 0, 16'hFFFF, 16'h8000, 0);
    // R10: block load without abort gives no request
    run("R10", 2, 1, 0, 0, 1, 0, 16'h0C01, 16'h0, 1);

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule